// File: doc/BRIEF.md
# Keyed Watchdog Timer with Armed Reload

This block watches over a processor by counting toward an overflow that ends in a reset request. A divider stage cuts the system clock into a slow enable. A prescaler chain then divides that enable by a power of two. An up-counter that is `TMR_W` bits wide advances once per prescaler wrap. When the counter wraps past its all-ones value, the block emits a one-cycle reset request. Software keeps the system alive by writing a fresh start value into the counter before that happens. Each such write is honoured only if a separate load-enable flag was armed in an earlier cycle, and the flag drops again as soon as a load is taken. A stray single write therefore cannot restart the count.

A key register has two jobs. It switches the watchdog off when it holds the value 0x55. It also grants the power-down request bit its effect, and only while it holds that same value. Any other key value keeps the watchdog counting and blocks power-down.

After a system reset the counter stands still. The first accepted reload starts it. From then on it runs for as long as the key allows, and this includes periods when the processor is idle.

Top module: `keyed_wdt`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, `wdt_rst`, `pd_eff`, `armed` and `running` are low and `enabled` is high, because the key reset value is 0x00.
- R2: When the key holds 0x55, `enabled` is low and `pd_eff` follows the stored power-down bit. For any other key value, `enabled` is high and `pd_eff` is low.
- R3: A reload write is accepted only if `armed` was already high before that clock edge. An arm write in the same cycle does not make that reload count. An ignored reload changes no output.
- R4: An accepted reload clears `armed` at the same edge. The clear wins over an arm write in that cycle.
- R5: An arm write sets `armed` to the written bit (1 sets it, 0 clears it).
- R6: After reset, `running` stays low and no reset request occurs until the first accepted reload. From then on `running` is high.
- R7: An accepted reload of value V at clock edge E gives a one-cycle `wdt_rst` pulse. The pulse is high after edge E + (2^TMR_W − V)·DIV·2^PRE_W, provided the watchdog is enabled throughout.
- R8: An accepted reload clears the divider and the prescaler, so the interval in R7 does not depend on the phase of the chain.
- R9: A reload accepted at the very edge where the counter would overflow suppresses that `wdt_rst` pulse and starts a new interval.
- R10: After an overflow the counter continues from zero. With no reload, the next pulse follows 2^TMR_W·DIV·2^PRE_W counting cycles later.
- R11: While the key holds 0x55, the divider, prescaler and counter hold their values. Counting resumes with the same remaining time once the key changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key register write strobe |
| key_wdata | input | 8 | Key write data |
| rld_we | input | 1 | Reload register write strobe |
| rld_wdata | input | TMR_W | Reload start value |
| arm_we | input | 1 | Load-enable flag write strobe |
| arm_wdata | input | 1 | Load-enable flag write value |
| pd_we | input | 1 | Power-down bit write strobe |
| pd_wdata | input | 1 | Power-down bit write value |
| wdt_rst | output | 1 | One-cycle reset request on overflow |
| pd_eff | output | 1 | Power-down request after key gating |
| enabled | output | 1 | Watchdog enabled by key |
| running | output | 1 | Counter started by an accepted reload |
| armed | output | 1 | Load-enable flag |

## Verification
Two pairs of events can fall in the same cycle. The first pair is an accepted reload and the counter overflow. The bench provokes it by arming the flag early, then following its own elapsed-cycle model until one counting edge remains, and writing the reload in exactly that cycle. It passes only if no reset pulse appears and the new interval runs to its full length. The second pair is an arm write and a reload write in the same cycle. The bench judges it by checking that the reload is ignored while the flag still becomes set. The per-cycle model also drives reloads at varied prescaler phases and pauses the count with the key.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
    localparam int unsigned KEY_W = 8;
    localparam logic [KEY_W-1:0] KEY_OPEN = 8'h55;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic             armed;
        logic             running;
        logic             pd_req;
    } ctrl_t;

    typedef struct packed {
        logic accept;
        logic count_en;
    } cmd_t;

    function automatic logic key_opens(input logic [KEY_W-1:0] k);
        return k == KEY_OPEN;
    endfunction
endpackage

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [KEY_W-1:0] key_wdata,
    input  logic             arm_we,
    input  logic             arm_wdata,
    input  logic             rld_we,
    input  logic             pd_we,
    input  logic             pd_wdata,
    output ctrl_t            st,
    output cmd_t             cmd
);
    // a reload counts only against the flag as it stood before this edge
    always_comb begin
        cmd.accept   = rld_we && st.armed;
        cmd.count_en = st.running && !key_opens(st.key);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            if (key_we) st.key    <= key_wdata;
            if (pd_we)  st.pd_req <= pd_wdata;
            if (cmd.accept) begin
                st.armed   <= 1'b0;
                st.running <= 1'b1;
            end else if (arm_we) begin
                st.armed   <= arm_wdata;
            end
        end
    end
endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int unsigned DIV   = 6,
    parameter int unsigned PRE_W = 11
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int unsigned DIV_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic             div_tick;
    logic [PRE_W-1:0] pre_q;

    generate
        if (DIV > 1) begin : g_div
            logic [DIV_W-1:0] div_q;
            logic             div_last;
            assign div_last = (div_q == DIV_W'(DIV - 1));
            assign div_tick = run && div_last;
            always_ff @(posedge clk) begin
                if (rst || clear)   div_q <= '0;
                else if (run)       div_q <= div_last ? '0 : div_q + 1'b1;
            end
        end else begin : g_nodiv
            assign div_tick = run;
        end
    endgenerate

    assign tick = div_tick && (&pre_q);

    always_ff @(posedge clk) begin
        if (rst || clear)  pre_q <= '0;
        else if (div_tick) pre_q <= pre_q + 1'b1;
    end
endmodule

// File: rtl/kwdt_timer.sv
module kwdt_timer #(
    parameter int unsigned TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    input  logic             tick,
    output logic             ovf_pulse
);
    logic [TMR_W-1:0] tmr_q;
    logic             wrap;

    assign wrap = tick && (&tmr_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q     <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            // a load at the overflow edge takes the place of the overflow
            ovf_pulse <= wrap && !load;
            if (load)      tmr_q <= load_val;
            else if (tick) tmr_q <= tmr_q + 1'b1;
        end
    end
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
    import kwdt_pkg::*;
#(
    parameter int unsigned DIV   = 6,
    parameter int unsigned PRE_W = 11,
    parameter int unsigned TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_we,
    input  logic [7:0]       key_wdata,
    input  logic             rld_we,
    input  logic [TMR_W-1:0] rld_wdata,
    input  logic             arm_we,
    input  logic             arm_wdata,
    input  logic             pd_we,
    input  logic             pd_wdata,
    output logic             wdt_rst,
    output logic             pd_eff,
    output logic             enabled,
    output logic             running,
    output logic             armed
);
    ctrl_t st;
    cmd_t  cmd;
    logic  tmr_tick;

    kwdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .key_we    (key_we),
        .key_wdata (key_wdata),
        .arm_we    (arm_we),
        .arm_wdata (arm_wdata),
        .rld_we    (rld_we),
        .pd_we     (pd_we),
        .pd_wdata  (pd_wdata),
        .st        (st),
        .cmd       (cmd)
    );

    kwdt_prescale #(.DIV(DIV), .PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd.accept),
        .run   (cmd.count_en),
        .tick  (tmr_tick)
    );

    kwdt_timer #(.TMR_W(TMR_W)) u_tmr (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd.accept),
        .load_val  (rld_wdata),
        .tick      (tmr_tick),
        .ovf_pulse (wdt_rst)
    );

    assign enabled = !key_opens(st.key);
    assign pd_eff  = st.pd_req && key_opens(st.key);
    assign running = st.running;
    assign armed   = st.armed;
endmodule

// File: rtl/keyed_wdt_chk.sv
module keyed_wdt_chk (
    input logic clk,
    input logic rst,
    input logic rld_we,
    input logic wdt_rst,
    input logic pd_eff,
    input logic enabled,
    input logic running,
    input logic armed
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!wdt_rst && !pd_eff && !running && !armed && enabled));

    // R2
    pd_gated_chk: assert property (@(posedge clk) disable iff (rst)
        pd_eff |-> !enabled);

    // R4
    arm_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (rld_we && armed) |=> !armed);

    // R3
    unarmed_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (rld_we && !armed && !running) |=> !running);

    // R6
    pulse_needs_start_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> running);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst);

    // R9
    reload_beats_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (rld_we && armed) |=> !wdt_rst);

    // R11
    paused_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !enabled |=> !wdt_rst);
endmodule

bind keyed_wdt keyed_wdt_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .rld_we  (rld_we),
    .wdt_rst (wdt_rst),
    .pd_eff  (pd_eff),
    .enabled (enabled),
    .running (running),
    .armed   (armed)
);

// File: tb/test_keyed_wdt.sv
module test_keyed_wdt;
    localparam int DIV   = 3;
    localparam int PRE_W = 2;
    localparam int TMR_W = 8;
    localparam int T     = DIV * (2 ** PRE_W);
    localparam int FULL  = 2 ** TMR_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic key_we = 1'b0, rld_we = 1'b0, arm_we = 1'b0, pd_we = 1'b0;
    logic arm_wdata = 1'b0, pd_wdata = 1'b0;
    logic [7:0] key_wdata = '0;
    logic [TMR_W-1:0] rld_wdata = '0;
    logic wdt_rst, pd_eff, enabled, running, armed;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    int pulses = 0;

    // reference model state
    int   m_key = 0;
    bit   m_armed = 0, m_run = 0, m_pd = 0, m_rst = 0;
    int   m_e = 0, m_N = 0;
    bit   done = 0;

    always #4 clk = ~clk;

    keyed_wdt #(.DIV(DIV), .PRE_W(PRE_W), .TMR_W(TMR_W)) i_keyed_wdt (
        .clk(clk), .rst(rst),
        .key_we(key_we), .key_wdata(key_wdata),
        .rld_we(rld_we), .rld_wdata(rld_wdata),
        .arm_we(arm_we), .arm_wdata(arm_wdata),
        .pd_we(pd_we), .pd_wdata(pd_wdata),
        .wdt_rst(wdt_rst), .pd_eff(pd_eff), .enabled(enabled),
        .running(running), .armed(armed)
    );

    always @(posedge clk) begin
        bit acc, en, nr;
        cycles++;
        if (rst) begin
            m_key = 0; m_armed = 0; m_run = 0; m_pd = 0;
            m_e = 0; m_N = 0; m_rst = 0;
        end else begin
            acc = rld_we && m_armed;
            en  = (m_key != 8'h55);
            nr  = 0;
            if (acc) begin
                m_e = 0; m_N = (FULL - int'(rld_wdata)) * T; m_run = 1;
            end else if (m_run && en) begin
                m_e++;
                if (m_e == m_N) begin
                    nr = 1; m_e = 0; m_N = FULL * T;
                end
            end
            if (acc) m_armed = 0;
            else if (arm_we) m_armed = arm_wdata;
            if (key_we) m_key = int'(key_wdata);
            if (pd_we)  m_pd = pd_wdata;
            m_rst = nr;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cycles, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R7/R9/R10 wdt_rst", wdt_rst, m_rst);
            chk("R2 pd_eff", pd_eff, m_pd && (m_key == 8'h55));
            chk("R2/R11 enabled", enabled, m_key != 8'h55);
            chk("R6 running", running, m_run);
            chk("R3/R4/R5 armed", armed, m_armed);
            if (wdt_rst) pulses++;
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic arm(input logic v);
        @(negedge clk); arm_we = 1; arm_wdata = v;
        @(negedge clk); arm_we = 0;
    endtask

    task automatic reload(input int v);
        @(negedge clk); rld_we = 1; rld_wdata = TMR_W'(v);
        @(negedge clk); rld_we = 0;
    endtask

    task automatic set_key(input int v);
        @(negedge clk); key_we = 1; key_wdata = 8'(v);
        @(negedge clk); key_we = 0;
    endtask

    task automatic set_pd(input logic v);
        @(negedge clk); pd_we = 1; pd_wdata = v;
        @(negedge clk); pd_we = 0;
    endtask

    task automatic wait_pulse(input int limit);
        int start;
        start = pulses;
        for (int i = 0; i < limit && pulses == start; i++) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        idle(3);
        @(negedge clk); rst = 0;
        idle(5);
        // R6: stopped, no pulse before first accepted load
        idle(40);
        // R3: unarmed reload ignored
        reload(10);
        idle(10);
        // R3/R5: arm and reload together: reload ignored, flag set
        @(negedge clk); arm_we = 1; arm_wdata = 1; rld_we = 1; rld_wdata = 8'd20;
        @(negedge clk); arm_we = 0; rld_we = 0;
        // R5: clear with a 0 write, then set again
        arm(1'b0);
        arm(1'b1);
        // R4/R6/R7: accepted reload starts count, flag self-clears
        reload(250);
        wait_pulse(FULL * T + 50);
        idle(3);
        // R10: no reload, runs on to next wrap
        wait_pulse(FULL * T + 50);
        // R8: reloads at varied prescaler phases
        for (int k = 0; k < 5; k++) begin
            idle(k * 2 + 1);
            arm(1'b1);
            reload(240 + k);
        end
        // R4: arm write with an accepted reload, clear wins
        arm(1'b1);
        @(negedge clk); arm_we = 1; arm_wdata = 1; rld_we = 1; rld_wdata = 8'd252;
        @(negedge clk); arm_we = 0; rld_we = 0;
        wait_pulse(FULL * T + 50);
        // R9: reload exactly at the overflow edge
        arm(1'b1);
        while (!(m_run && m_key != 8'h55 && m_e == m_N - 1)) @(negedge clk);
        rld_we = 1; rld_wdata = 8'd245;
        @(negedge clk); rld_we = 0;
        wait_pulse(FULL * T + 50);
        // R11/R2: pause with the key, power-down gating
        arm(1'b1);
        reload(230);
        idle(50);
        set_pd(1'b1);
        set_key(8'h55);
        idle(200);
        set_key(8'h54);
        wait_pulse(FULL * T + 50);
        set_key(8'h55);
        set_pd(1'b0);
        set_pd(1'b1);
        set_key(8'h00);
        idle(20);
        // R1: reset in the middle of a count
        arm(1'b1);
        reload(200);
        idle(30);
        @(negedge clk); rst = 1;
        idle(3);
        @(negedge clk); rst = 0;
        idle(FULL * T / 4);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        done = 1;
        $display("FAIL watchdog expired at cycle %0d: actual hung expected finished", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule